// File: doc/BRIEF.md
# Dual-Channel DDR I/Q Transmit Bridge

This block sits between user transmit logic and a data converter that takes interleaved I/Q samples on one narrow double-data-rate bus. It serves two RF channels, A and B. Each channel receives a 12-bit I word and a 12-bit Q word once per sample clock. It captures the two words as a pair on the rising edge. It then drives I onto the channel's bus while the sample clock is high and Q while it is low.

For the converter to capture that bus, each channel also sends out a data clock. This clock comes from a second sample clock, which the user supplies and which lags the main one by a quarter period. The data clock is produced by the same kind of double-data-rate output register as the data bits. It therefore switches at the same point in the output path, and its edges fall in the middle of each data phase. A per-channel I/Q select line is routed straight from input to output. The converter ignores this line in double-data-rate mode, and it is normally tied low.

An asynchronous active-low reset clears the data buses and holds both forwarded clocks low at once. Release is synchronised separately into each clock domain.

Top module: `dual_ddr_tx_bridge`

## Requirements
- R1: After reset release, while the sample clock is high, each channel's bus carries the I word that was present at that channel's I input at the most recent rising edge of the sample clock.
- R2: After reset release, while the sample clock is low, each channel's bus carries the Q word that was captured on that same rising edge. It therefore shows the Q word that belongs with the I word shown in the preceding high phase.
- R3: Input changes between two rising edges of the sample clock do not reach either bus until the next rising edge. A value driven and then replaced before that edge never appears.
- R4: Channels A and B are independent. Each bus shows only its own channel's words, even when the two channels carry different values in the same cycle.
- R5: Once running, each forwarded data clock is high while the 90-degree sample clock is high and low while it is low. It toggles once per sample period and lags the data phases by a quarter period.
- R6: Each I/Q select output equals its channel's select input combinationally, with no register on the path, and follows it during reset as well.
- R7: While the reset input is low, both buses read zero and both forwarded clocks read low, whatever the sample inputs are. This takes effect as soon as reset is asserted, without waiting for a clock edge.
- R8: After reset is released, each domain stays cleared for two rising edges of its own clock, which is the synchroniser depth. The first sample pair is captured on the third rising edge of the sample clock. The forwarded clock starts on the third rising edge of the 90-degree clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_tx | input | 1 | Transmit sample clock; sample inputs are synchronous to it |
| clk_tx90 | input | 1 | Copy of clk_tx lagging it by 90 degrees |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_i | input | 12 | Channel A I sample |
| a_q | input | 12 | Channel A Q sample |
| a_sel | input | 1 | Channel A I/Q select input |
| b_i | input | 12 | Channel B I sample |
| b_q | input | 12 | Channel B Q sample |
| b_sel | input | 1 | Channel B I/Q select input |
| a_bus | output | 12 | Channel A interleaved DDR data bus |
| a_fclk | output | 1 | Channel A forwarded data clock |
| a_sel_out | output | 1 | Channel A I/Q select toward the converter |
| b_bus | output | 12 | Channel B interleaved DDR data bus |
| b_fclk | output | 1 | Channel B forwarded data clock |
| b_sel_out | output | 1 | Channel B I/Q select toward the converter |

## Verification
On every clock phase once the design is running, the assertions compare each bus with the I or Q word the checker itself captured at the previous rising edge. They do this for both channels, so a swapped phase or a crossed channel shows up on every cycle. They also check the level of each forwarded clock on both edges of the 90-degree clock, and the zeroed outputs during reset. The bench's scenarios are needed for everything else: that a value driven and then replaced mid-cycle never leaks onto the bus, the exact edge count before outputs come alive after reset release, the immediate clearing when reset is asserted mid-cycle, and the combinational select passthrough.

// File: rtl/ddrtx_pkg.sv
package ddrtx_pkg;
  localparam int DEF_SAMPLE_W    = 12;
  localparam int DEF_SYNC_STAGES = 2;
  localparam int N_LANES         = 2;

  typedef enum int {
    LANE_A = 0,
    LANE_B = 1
  } lane_e;
endpackage

// File: rtl/ddrtx_rst_sync.sv
// Reset synchroniser: asserts asynchronously, releases after STAGES edges.
module ddrtx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_r;
  logic [STAGES-1:0] chain_nx;
  logic [STAGES:0]   shifted;

  assign shifted = {chain_r, 1'b1};

  always_comb begin
    chain_nx = shifted[STAGES-1:0];
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_r <= '0;
    end else begin
      chain_r <= chain_nx;
    end
  end

  assign srst_n = chain_r[STAGES-1];
endmodule

// File: rtl/ddrtx_oddr.sv
// Behavioural DDR output cell: both phases registered on the rising edge,
// the rise word shown while clk is high, the fall word while it is low.
module ddrtx_oddr #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d_rise,
  input  logic [W-1:0] d_fall,
  output logic [W-1:0] q
);
  logic [W-1:0] hi_r, lo_r;
  logic [W-1:0] hi_nx, lo_nx;

  always_comb begin
    hi_nx = hi_r;
    lo_nx = lo_r;
    if (en) begin
      hi_nx = d_rise;
      lo_nx = d_fall;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_r <= '0;
      lo_r <= '0;
    end else begin
      hi_r <= hi_nx;
      lo_r <= lo_nx;
    end
  end

  assign q = clk ? hi_r : lo_r;
endmodule

// File: rtl/ddrtx_lane.sv
// One RF channel: data DDR cell, clock-forwarding DDR cell, select passthrough.
module ddrtx_lane #(
  parameter int W = 12
) (
  input  logic         clk_s,
  input  logic         clk_s90,
  input  logic         rst_s_n,
  input  logic         rst_90_n,
  input  logic         en_s,
  input  logic         en_90,
  input  logic [W-1:0] i_word,
  input  logic [W-1:0] q_word,
  input  logic         sel_in,
  output logic [W-1:0] bus,
  output logic         fclk,
  output logic         sel_out
);
  logic [0:0] fclk_vec;

  ddrtx_oddr #(.W(W)) u_data (
    .clk    (clk_s),
    .rst_n  (rst_s_n),
    .en     (en_s),
    .d_rise (i_word),
    .d_fall (q_word),
    .q      (bus)
  );

  ddrtx_oddr #(.W(1)) u_fwd (
    .clk    (clk_s90),
    .rst_n  (rst_90_n),
    .en     (en_90),
    .d_rise (1'b1),
    .d_fall (1'b0),
    .q      (fclk_vec)
  );

  assign fclk    = fclk_vec[0];
  assign sel_out = sel_in;
endmodule

// File: rtl/dual_ddr_tx_bridge.sv
module dual_ddr_tx_bridge
  import ddrtx_pkg::*;
#(
  parameter int SAMPLE_W    = DEF_SAMPLE_W,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic                clk_tx,
  input  logic                clk_tx90,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] a_i,
  input  logic [SAMPLE_W-1:0] a_q,
  input  logic                a_sel,
  input  logic [SAMPLE_W-1:0] b_i,
  input  logic [SAMPLE_W-1:0] b_q,
  input  logic                b_sel,
  output logic [SAMPLE_W-1:0] a_bus,
  output logic                a_fclk,
  output logic                a_sel_out,
  output logic [SAMPLE_W-1:0] b_bus,
  output logic                b_fclk,
  output logic                b_sel_out
);
  logic rst_s_n, rst_90_n;

  logic [N_LANES-1:0][SAMPLE_W-1:0] i_all, q_all, bus_all;
  logic [N_LANES-1:0]               sel_all, sel_o_all, fclk_all;

  ddrtx_rst_sync #(.STAGES(SYNC_STAGES)) u_rs_s (
    .clk    (clk_tx),
    .arst_n (rst_n),
    .srst_n (rst_s_n)
  );

  ddrtx_rst_sync #(.STAGES(SYNC_STAGES)) u_rs_90 (
    .clk    (clk_tx90),
    .arst_n (rst_n),
    .srst_n (rst_90_n)
  );

  assign i_all[LANE_A]   = a_i;
  assign q_all[LANE_A]   = a_q;
  assign sel_all[LANE_A] = a_sel;
  assign i_all[LANE_B]   = b_i;
  assign q_all[LANE_B]   = b_q;
  assign sel_all[LANE_B] = b_sel;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    ddrtx_lane #(.W(SAMPLE_W)) u_lane (
      .clk_s    (clk_tx),
      .clk_s90  (clk_tx90),
      .rst_s_n  (rst_s_n),
      .rst_90_n (rst_90_n),
      .en_s     (rst_s_n),
      .en_90    (rst_90_n),
      .i_word   (i_all[g]),
      .q_word   (q_all[g]),
      .sel_in   (sel_all[g]),
      .bus      (bus_all[g]),
      .fclk     (fclk_all[g]),
      .sel_out  (sel_o_all[g])
    );
  end

  assign a_bus     = bus_all[LANE_A];
  assign a_fclk    = fclk_all[LANE_A];
  assign a_sel_out = sel_o_all[LANE_A];
  assign b_bus     = bus_all[LANE_B];
  assign b_fclk    = fclk_all[LANE_B];
  assign b_sel_out = sel_o_all[LANE_B];
endmodule

// File: rtl/ddrtx_bridge_chk.sv
module ddrtx_bridge_chk #(
  parameter int W      = 12,
  parameter int STAGES = 2
) (
  input logic         clk,
  input logic         clk90,
  input logic         rst_n,
  input logic [W-1:0] a_i,
  input logic [W-1:0] a_q,
  input logic [W-1:0] b_i,
  input logic [W-1:0] b_q,
  input logic [W-1:0] a_bus,
  input logic [W-1:0] b_bus,
  input logic         a_fclk,
  input logic         b_fclk
);
  localparam int ARM = STAGES + 1;

  logic [7:0]   live_cnt;
  logic         armed;
  logic [W-1:0] ai_c, aq_c, bi_c, bq_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_cnt <= '0;
    end else if (live_cnt != 8'hFF) begin
      live_cnt <= live_cnt + 8'd1;
    end
  end

  assign armed = (int'(live_cnt) >= ARM);

  always_ff @(posedge clk) begin
    ai_c <= a_i;
    aq_c <= a_q;
    bi_c <= b_i;
    bq_c <= b_q;
  end

  AST_A_HI_IS_I: assert property (@(negedge clk) disable iff (!rst_n || !armed)
    a_bus == ai_c); // R1
  AST_A_LO_IS_Q: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    a_bus == aq_c); // R2
  AST_B_HI_IS_I: assert property (@(negedge clk) disable iff (!rst_n || !armed)
    b_bus == bi_c); // R4
  AST_B_LO_IS_Q: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    b_bus == bq_c); // R4
  AST_FCLK_HIGH: assert property (@(negedge clk90) disable iff (!rst_n || !armed)
    a_fclk && b_fclk); // R5
  AST_FCLK_LOW: assert property (@(posedge clk90) disable iff (!rst_n || !armed)
    !a_fclk && !b_fclk); // R5

  always @(negedge clk) begin
    if (rst_n == 1'b0) begin
      AST_RESET_CLEAR: assert (a_bus == '0 && b_bus == '0 && !a_fclk && !b_fclk); // R7
    end
  end
endmodule

bind dual_ddr_tx_bridge ddrtx_bridge_chk #(.W(SAMPLE_W), .STAGES(SYNC_STAGES)) u_chk (
  .clk    (clk_tx),
  .clk90  (clk_tx90),
  .rst_n  (rst_n),
  .a_i    (a_i),
  .a_q    (a_q),
  .b_i    (b_i),
  .b_q    (b_q),
  .a_bus  (a_bus),
  .b_bus  (b_bus),
  .a_fclk (a_fclk),
  .b_fclk (b_fclk)
);

// File: tb/dual_ddr_tx_bridge_test.sv
module dual_ddr_tx_bridge_test;
  localparam int CLK_PERIOD = 40;
  localparam int EIGHTH     = CLK_PERIOD / 8;
  localparam int W          = 12;
  localparam int N_VEC      = 400;

  logic         clk_tx, clk_tx90, rst_n;
  logic [W-1:0] a_i, a_q, b_i, b_q;
  logic         a_sel, b_sel;
  logic [W-1:0] a_bus, b_bus;
  logic         a_fclk, b_fclk, a_sel_out, b_sel_out;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] dr_ai, dr_aq, dr_bi, dr_bq;

  dual_ddr_tx_bridge uut (
    .clk_tx    (clk_tx),
    .clk_tx90  (clk_tx90),
    .rst_n     (rst_n),
    .a_i       (a_i),
    .a_q       (a_q),
    .a_sel     (a_sel),
    .b_i       (b_i),
    .b_q       (b_q),
    .b_sel     (b_sel),
    .a_bus     (a_bus),
    .a_fclk    (a_fclk),
    .a_sel_out (a_sel_out),
    .b_bus     (b_bus),
    .b_fclk    (b_fclk),
    .b_sel_out (b_sel_out)
  );

  initial begin
    clk_tx = 1'b0;
    forever #(CLK_PERIOD/2) clk_tx = ~clk_tx;
  end

  initial begin
    clk_tx90 = 1'b0;
    #(3*CLK_PERIOD/4);
    forever begin
      clk_tx90 = 1'b1;
      #(CLK_PERIOD/2);
      clk_tx90 = 1'b0;
      #(CLK_PERIOD/2);
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] pat(input int k, input int ch, input int iq);
    int sel;
    sel = ch * 2 + iq;
    if (k < W) return W'(1) << ((k + sel) % W);
    if (k < 2*W) return ~(W'(1) << ((k + sel) % W));
    return W'((k * (37 + 74*ch + 13*iq) + 1365*ch + 273*iq) & ((1 << W) - 1));
  endfunction

  task automatic drive(input logic [W-1:0] ai, aq, bi, bq);
    a_i = ai; a_q = aq; b_i = bi; b_q = bq;
  endtask

  // One sample period. Starts waiting for a rising edge, ends at +P*9/10.
  task automatic run_cycle(input string tag_d, input bit dat_on, input bit fck_on,
                           input logic [W-1:0] n_ai, n_aq, n_bi, n_bq);
    logic [W-1:0] e_ai, e_aq, e_bi, e_bq;
    @(posedge clk_tx);
    e_ai = dat_on ? dr_ai : '0;
    e_aq = dat_on ? dr_aq : '0;
    e_bi = dat_on ? dr_bi : '0;
    e_bq = dat_on ? dr_bq : '0;
    #(EIGHTH);
    chk({tag_d, " R1 A I phase"}, 32'(a_bus), 32'(e_ai));
    chk({tag_d, " R4 B I phase"}, 32'(b_bus), 32'(e_bi));
    chk("R5 fclk low before 90 edge", {30'd0, a_fclk, b_fclk}, 32'd0);
    #(2*EIGHTH);
    chk({tag_d, " R1 A I phase late"}, 32'(a_bus), 32'(e_ai));
    chk({tag_d, " R4 B I phase late"}, 32'(b_bus), 32'(e_bi));
    chk("R5 fclk high in 90 high", {30'd0, a_fclk, b_fclk}, fck_on ? 32'd3 : 32'd0);
    #1;
    drive(~n_ai, ~n_aq, ~n_bi, ~n_bq);   // R3: replaced before the next edge
    #(2*EIGHTH - 1);
    chk({tag_d, " R2 A Q phase"}, 32'(a_bus), 32'(e_aq));
    chk({tag_d, " R4 B Q phase"}, 32'(b_bus), 32'(e_bq));
    chk("R5 fclk high early low phase", {30'd0, a_fclk, b_fclk}, fck_on ? 32'd3 : 32'd0);
    #(2*EIGHTH);
    chk({tag_d, " R3 A Q held"}, 32'(a_bus), 32'(e_aq));
    chk({tag_d, " R3 B Q held"}, 32'(b_bus), 32'(e_bq));
    chk("R5 fclk low late", {30'd0, a_fclk, b_fclk}, 32'd0);
    #1;
    drive(n_ai, n_aq, n_bi, n_bq);
    dr_ai = n_ai; dr_aq = n_aq; dr_bi = n_bi; dr_bq = n_bq;
  endtask

  task automatic sel_check();
    a_sel = 1'b1; b_sel = 1'b0; #1;
    chk("R6 sel pass 10", {30'd0, a_sel_out, b_sel_out}, 32'd2);
    a_sel = 1'b0; b_sel = 1'b1; #1;
    chk("R6 sel pass 01", {30'd0, a_sel_out, b_sel_out}, 32'd1);
    a_sel = 1'b0; b_sel = 1'b0; #1;
    chk("R6 sel pass 00", {30'd0, a_sel_out, b_sel_out}, 32'd0);
  endtask

  task automatic release_and_start(input int base);
    rst_n = 1'b1;
    run_cycle("R8 edge1", 1'b0, 1'b0, pat(base,0,0), pat(base,0,1), pat(base,1,0), pat(base,1,1));
    run_cycle("R8 edge2", 1'b0, 1'b0, pat(base,0,0), pat(base,0,1), pat(base,1,0), pat(base,1,1));
    run_cycle("R8 edge3", 1'b1, 1'b1, pat(base+1,0,0), pat(base+1,0,1), pat(base+1,1,0), pat(base+1,1,1));
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b1;
    a_sel = 1'b0; b_sel = 1'b0;
    drive('0, '0, '0, '0);
    dr_ai = '0; dr_aq = '0; dr_bi = '0; dr_bq = '0;
    #1 rst_n = 1'b0;
    sel_check();                                   // R6 during reset
    for (int k = 0; k < 3; k++)                    // R7 inputs ignored in reset
      run_cycle("R7 hold", 1'b0, 1'b0, 12'hFFF, 12'hA5A, 12'h5A5, 12'h123);

    release_and_start(0);

    for (int k = 1; k < N_VEC; k++)
      run_cycle("sweep", 1'b1, 1'b1, pat(k+1,0,0), pat(k+1,0,1), pat(k+1,1,0), pat(k+1,1,1));

    sel_check();                                   // R6 while running

    // Asynchronous reset in the middle of an I phase with clk90 high
    @(posedge clk_tx);
    #(3*EIGHTH);
    rst_n = 1'b0;
    #1;
    chk("R7 A bus cleared at once", 32'(a_bus), 32'd0);
    chk("R7 B bus cleared at once", 32'(b_bus), 32'd0);
    chk("R7 fclk forced low", {30'd0, a_fclk, b_fclk}, 32'd0);
    #(5*EIGHTH);
    sel_check();
    run_cycle("R7 mid hold", 1'b0, 1'b0, 12'h0F0, 12'hF0F, 12'h3C3, 12'hC3C);
    run_cycle("R7 mid hold", 1'b0, 1'b0, 12'h0F0, 12'hF0F, 12'h3C3, 12'hC3C);

    release_and_start(500);
    for (int k = 0; k < 20; k++)
      run_cycle("post", 1'b1, 1'b1, pat(k+600,0,0), pat(k+600,0,1), pat(k+600,1,0), pat(k+600,1,1));

    finish_run();
  end
endmodule